// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects an on-chip request port, carrying 16-bit or 32-bit reads and writes, to a single bank of asynchronous external memory with a 16-bit data bus. Every halfword transfer on the bus has three phases, each counted in clock cycles. The setup phase comes first and asserts the chip select with a steady address. The strobe phase follows and asserts output enable for a read or write enable for a write. The hold phase comes last and keeps the select and address while both strobes are released. A 32-bit request becomes two back-to-back halfword transfers: the low half first and then the high half.

The three phase lengths sit in a small timing register set. After reset it holds the slowest settings: a 4-cycle setup, a 15-cycle strobe and a 3-cycle hold. The set can be rewritten at any time. Each access copies the timing at the moment it is accepted, so a rewrite never stretches or cuts an access that is already on the bus. The bank window starts at byte address 0x2000_0000. The bus address is the halfword index of the offset from that base.

Requests use a valid/ready handshake. Completion is a one-cycle done pulse, and for a read the assembled data is presented in that same cycle.

Top module: `xbus_async_ctrl`

## Requirements
- R1: After reset the timing set holds setup 4, strobe 15 and hold 3. A 16-bit access started with no reprogramming keeps chip select low for 22 cycles, and its strobe begins in the 5th cycle after acceptance.
- R2: For each halfword with effective lengths S, A and H, chip select is low for S+A+H consecutive cycles. The strobe (output enable for reads, write enable for writes) is low only for the A cycles that follow the first S cycles.
- R3: A 16-bit access raises rsp_done for exactly one cycle, S+A+H+1 cycles after the accepting edge. For a read, rsp_rdata then holds the bus data sampled in the last strobe cycle, zero-extended in bits 31:16.
- R4: A 32-bit access (req_wide=1) performs two halfword transfers with done at 2(S+A+H)+1 cycles. The low halfword goes at the even halfword address and the high halfword at the next address. Read data returns as {second, first}.
- R5: During a write, ebus_dout_en is high for the whole chip select span. ebus_dout carries req_wdata[15:0] for a 16-bit write or the low halfword, and req_wdata[31:16] for the high halfword.
- R6: ebus_addr equals bits 20:1 of (req_addr − 0x2000_0000). For a 32-bit access bit 0 of that index is forced to 0. The address stays constant through each halfword's strobe.
- R7: req_ready is high only while no access is in progress. A request is taken on a rising edge where req_valid and req_ready are both high, and chip select falls in the next cycle.
- R8: A cfg_we pulse loads cfg_setup, cfg_strobe and cfg_hold. The new values apply only to requests accepted after the loading edge, and an access in flight keeps the lengths it started with. A programmed 0 acts as 1 cycle.
- R9: Output enable and write enable are never low together. While idle, chip select and both strobes are high and ebus_dout_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the timing set |
| cfg_setup | input | 4 | Setup phase length in cycles (0 means 1) |
| cfg_strobe | input | 4 | Strobe phase length in cycles (0 means 1) |
| cfg_hold | input | 4 | Hold phase length in cycles (0 means 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| ebus_cs_n | output | 1 | Chip select, active low |
| ebus_oe_n | output | 1 | Output enable, active low |
| ebus_we_n | output | 1 | Write enable, active low |
| ebus_addr | output | 20 | Halfword address |
| ebus_dout | output | 16 | Write data to the bus |
| ebus_dout_en | output | 1 | Write data drive enable |
| ebus_din | input | 16 | Read data from the bus |

## Verification
The results fall due at fixed offsets from the accepting edge. Chip select falls one cycle after it. The strobe starts at cycle S+1, and done with read data arrives at cycle n(S+A+H)+1, where n is the number of halfwords. The bench counts cycles from that edge, samples every output on the falling edge of each counted cycle, and compares the done cycle, the low-select count, the strobe count, the first strobe cycle and the address and data captured during the strobes against its own formulas. It applies timing rewrites part-way through an access and predicts the old timing for that access and the new timing for the next one.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;
  localparam int TIM_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [TIM_W-1:0] setup;
    logic [TIM_W-1:0] strobe;
    logic [TIM_W-1:0] hold;
  } timing_t;

  // programmed value to cycle count: zero behaves as one cycle
  function automatic logic [TIM_W-1:0] eff_len(input logic [TIM_W-1:0] v);
    return (v == '0) ? TIM_W'(1) : v;
  endfunction

  // counter preload for a phase of the given programmed length
  function automatic logic [TIM_W-1:0] preload(input logic [TIM_W-1:0] v);
    return eff_len(v) - TIM_W'(1);
  endfunction
endpackage

// File: rtl/amc_timing_regs.sv
`timescale 1ns/1ps
module amc_timing_regs import amc_pkg::*; #(
  parameter int DEF_SETUP  = 4,
  parameter int DEF_STROBE = 15,
  parameter int DEF_HOLD   = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  timing_t tim_in,
  output timing_t tim_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim_q.setup  <= TIM_W'(DEF_SETUP);
      tim_q.strobe <= TIM_W'(DEF_STROBE);
      tim_q.hold   <= TIM_W'(DEF_HOLD);
    end else if (load) begin
      tim_q <= tim_in;
    end
  end
endmodule

// File: rtl/amc_phase_seq.sv
`timescale 1ns/1ps
module amc_phase_seq import amc_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    start_wide,
  input  timing_t tim_cur,
  output phase_e  phase,
  output logic    upper_half,
  output logic    strobe_last,
  output logic    xfer_end,
  output logic    access_done
);
  timing_t          tim_q;
  logic             wide_q;
  logic [TIM_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign strobe_last = (phase == PH_STROBE) && cnt_zero;
  assign xfer_end    = (phase == PH_HOLD) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      tim_q       <= '0;
      wide_q      <= 1'b0;
      upper_half  <= 1'b0;
      access_done <= 1'b0;
    end else begin
      access_done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          tim_q      <= tim_cur;
          wide_q     <= start_wide;
          upper_half <= 1'b0;
          cnt        <= preload(tim_cur.setup);
          phase      <= PH_SETUP;
        end
        PH_SETUP: if (cnt_zero) begin
          cnt   <= preload(tim_q.strobe);
          phase <= PH_STROBE;
        end else cnt <= cnt - TIM_W'(1);
        PH_STROBE: if (cnt_zero) begin
          cnt   <= preload(tim_q.hold);
          phase <= PH_HOLD;
        end else cnt <= cnt - TIM_W'(1);
        PH_HOLD: if (cnt_zero) begin
          if (wide_q && !upper_half) begin
            upper_half <= 1'b1;
            cnt        <= preload(tim_q.setup);
            phase      <= PH_SETUP;
          end else begin
            phase       <= PH_IDLE;
            access_done <= 1'b1;
          end
        end else cnt <= cnt - TIM_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amc_datapath.sv
`timescale 1ns/1ps
module amc_datapath import amc_pkg::*; #(
  parameter int              ADDR_W    = 32,
  parameter int              EXT_AW    = 20,
  parameter int              BUS_W     = 16,
  parameter logic [31:0]     BANK_BASE = 32'h2000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BUS_W-1:0]  req_wdata,
  input  phase_e              phase,
  input  logic                upper_half,
  input  logic                strobe_last,
  input  logic [BUS_W-1:0]    ebus_din,
  output logic                ebus_cs_n,
  output logic                ebus_oe_n,
  output logic                ebus_we_n,
  output logic [EXT_AW-1:0]   ebus_addr,
  output logic [BUS_W-1:0]    ebus_dout,
  output logic                ebus_dout_en,
  output logic [2*BUS_W-1:0]  rsp_rdata
);
  localparam int DATA_W = 2 * BUS_W;

  logic [ADDR_W-1:0] req_off;
  logic [EXT_AW-1:0] hw_idx;
  logic              unused_bits;
  logic              wr_q;
  logic [EXT_AW-1:0] hw_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              active;

  assign req_off     = req_addr - ADDR_W'(BANK_BASE);
  assign hw_idx      = {req_off[EXT_AW:2], req_off[1] & ~req_wide};
  assign unused_bits = ^{req_off[ADDR_W-1:EXT_AW+1], req_off[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      hw_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      hw_q    <= hw_idx;
      wdata_q <= req_wdata;
      rdata_q <= '0;
    end else if (strobe_last && !wr_q) begin
      if (upper_half) rdata_q[DATA_W-1:BUS_W] <= ebus_din;
      else            rdata_q[BUS_W-1:0]      <= ebus_din;
    end
  end

  assign active       = (phase != PH_IDLE);
  assign ebus_cs_n    = !active;
  assign ebus_oe_n    = !((phase == PH_STROBE) && !wr_q);
  assign ebus_we_n    = !((phase == PH_STROBE) && wr_q);
  assign ebus_dout_en = active && wr_q;
  assign ebus_addr    = hw_q | EXT_AW'(upper_half);
  assign ebus_dout    = upper_half ? wdata_q[DATA_W-1:BUS_W] : wdata_q[BUS_W-1:0];
  assign rsp_rdata    = rdata_q;
endmodule

// File: rtl/xbus_async_ctrl.sv
`timescale 1ns/1ps
module xbus_async_ctrl import amc_pkg::*; #(
  parameter int          ADDR_W     = 32,
  parameter int          EXT_AW     = 20,
  parameter int          BUS_W      = 16,
  parameter logic [31:0] BANK_BASE  = 32'h2000_0000,
  parameter int          DEF_SETUP  = 4,
  parameter int          DEF_STROBE = 15,
  parameter int          DEF_HOLD   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [TIM_W-1:0]    cfg_setup,
  input  logic [TIM_W-1:0]    cfg_strobe,
  input  logic [TIM_W-1:0]    cfg_hold,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BUS_W-1:0]  req_wdata,
  output logic                rsp_done,
  output logic [2*BUS_W-1:0]  rsp_rdata,
  output logic                ebus_cs_n,
  output logic                ebus_oe_n,
  output logic                ebus_we_n,
  output logic [EXT_AW-1:0]   ebus_addr,
  output logic [BUS_W-1:0]    ebus_dout,
  output logic                ebus_dout_en,
  input  logic [BUS_W-1:0]    ebus_din
);
  timing_t tim_in, tim_cur;
  phase_e  phase;
  logic    upper_half, strobe_last, xfer_end, start;

  assign tim_in    = '{setup: cfg_setup, strobe: cfg_strobe, hold: cfg_hold};
  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  amc_timing_regs #(.DEF_SETUP(DEF_SETUP), .DEF_STROBE(DEF_STROBE), .DEF_HOLD(DEF_HOLD)) u_tim (
    .clk(clk), .rst_n(rst_n), .load(cfg_we), .tim_in(tim_in), .tim_q(tim_cur));

  amc_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wide(req_wide), .tim_cur(tim_cur),
    .phase(phase), .upper_half(upper_half), .strobe_last(strobe_last),
    .xfer_end(xfer_end), .access_done(rsp_done));

  amc_datapath #(.ADDR_W(ADDR_W), .EXT_AW(EXT_AW), .BUS_W(BUS_W), .BANK_BASE(BANK_BASE)) u_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .phase(phase), .upper_half(upper_half),
    .strobe_last(strobe_last), .ebus_din(ebus_din), .ebus_cs_n(ebus_cs_n),
    .ebus_oe_n(ebus_oe_n), .ebus_we_n(ebus_we_n), .ebus_addr(ebus_addr),
    .ebus_dout(ebus_dout), .ebus_dout_en(ebus_dout_en), .rsp_rdata(rsp_rdata));
endmodule

// File: rtl/amc_checker.sv
`timescale 1ns/1ps
module amc_checker #(
  parameter int EXT_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dout_en,
  input logic [EXT_AW-1:0] addr,
  input logic              strobe_last,
  input logic              xfer_end
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && oe_n && we_n && !dout_en));
  assert_strobe_in_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !cs_n);
  assert_accept_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !cs_n);
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$past(xfer_end)) |-> $stable(addr));
  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dout_en);
  assert_done_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(xfer_end));
  assert_capture_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_last |-> !(oe_n && we_n));
endmodule

bind xbus_async_ctrl amc_checker #(.EXT_AW(EXT_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .cs_n(ebus_cs_n), .oe_n(ebus_oe_n), .we_n(ebus_we_n),
  .dout_en(ebus_dout_en), .addr(ebus_addr), .strobe_last(strobe_last),
  .xfer_end(xfer_end));

// File: tb/sim_xbus_async_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_async_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_setup = 4'd0, cfg_strobe = 4'd0, cfg_hold = 4'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [31:0] req_addr = 32'h0, req_wdata = 32'h0;
  logic        req_ready, rsp_done;
  logic [31:0] rsp_rdata;
  logic        ebus_cs_n, ebus_oe_n, ebus_we_n, ebus_dout_en;
  logic [19:0] ebus_addr;
  logic [15:0] ebus_dout, ebus_din;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;
  int m_s = 4, m_a = 15, m_h = 3;  // model of the effective phase lengths

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [15:0] bus_word(input logic [19:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {a[19:16], 12'h0};
  endfunction
  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction
  function automatic logic [19:0] exp_hw(input logic [31:0] a, input logic wide);
    logic [31:0] off;
    off = (a - 32'h2000_0000) >> 1;
    return wide ? {off[19:1], 1'b0} : off[19:0];
  endfunction

  assign ebus_din = bus_word(ebus_addr);

  xbus_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .ebus_cs_n(ebus_cs_n), .ebus_oe_n(ebus_oe_n),
    .ebus_we_n(ebus_we_n), .ebus_addr(ebus_addr), .ebus_dout(ebus_dout),
    .ebus_dout_en(ebus_dout_en), .ebus_din(ebus_din));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] s, input logic [3:0] a, input logic [3:0] h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_setup = s; cfg_strobe = a; cfg_hold = h;
    @(negedge clk);
    cfg_we = 1'b0;
    m_s = eff(s); m_a = eff(a); m_h = eff(h);
  endtask

  // one access; optionally rewrites the timing set in cycle 2 of it
  task automatic run_access(input logic wr, input logic wide, input logic [31:0] addr,
                            input logic [31:0] wdata, input bit mid_cfg,
                            input logic [3:0] ns, input logic [3:0] na, input logic [3:0] nh);
    int k, done_k, cs_cnt, oe_cnt, we_cnt, first_stb, rdy_cnt, drv_err, n, per;
    logic [19:0] a_first, a_last;
    logic [15:0] d_first, d_last;
    logic [31:0] rd, exp_rd;
    logic [19:0] hw;
    string rq;
    done_k = 0; cs_cnt = 0; oe_cnt = 0; we_cnt = 0; first_stb = 0; rdy_cnt = 0; drv_err = 0;
    a_first = '0; a_last = '0; d_first = '0; d_last = '0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (done_k == 0 && k < 300) begin
      if (!ebus_cs_n) cs_cnt++;
      if (!ebus_oe_n) oe_cnt++;
      if (!ebus_we_n) we_cnt++;
      if (!ebus_oe_n || !ebus_we_n) begin
        if (first_stb == 0) begin first_stb = k; a_first = ebus_addr; d_first = ebus_dout; end
        a_last = ebus_addr; d_last = ebus_dout;
      end
      if (wr && !ebus_cs_n && !ebus_dout_en) drv_err++;
      if (req_ready && !rsp_done) rdy_cnt++;
      if (mid_cfg && k == 2) begin
        cfg_we = 1'b1; cfg_setup = ns; cfg_strobe = na; cfg_hold = nh;
      end else cfg_we = 1'b0;
      if (rsp_done) begin
        done_k = k; rd = rsp_rdata;
      end else begin
        @(negedge clk); k++;
      end
    end
    cfg_we = 1'b0;
    n   = wide ? 2 : 1;
    per = m_s + m_a + m_h;
    rq  = wide ? "R4" : "R3";
    hw  = exp_hw(addr, wide);
    check({rq, " done cycle"}, done_k, n * per + 1);
    check("R2 select span", cs_cnt, n * per);
    check("R2 read strobe count", oe_cnt, wr ? 0 : n * m_a);
    check("R5 write strobe count", we_cnt, wr ? n * m_a : 0);
    check("R2 strobe start", first_stb, m_s + 1);
    check("R6 first address", a_first, hw);
    check("R4 last address", a_last, wide ? (hw | 20'd1) : hw);
    check("R7 not ready while busy", rdy_cnt, 0);
    if (wr) begin
      check("R5 drive enable", drv_err, 0);
      check("R5 low halfword data", d_first, wdata[15:0]);
      check("R5 last halfword data", d_last, wide ? wdata[31:16] : wdata[15:0]);
    end else begin
      exp_rd = wide ? {bus_word(hw | 20'd1), bus_word(hw)} : {16'h0, bus_word(hw)};
      check({rq, " read data"}, rd, exp_rd);
    end
    if (mid_cfg) begin m_s = eff(ns); m_a = eff(na); m_h = eff(nh); end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R7, R9)
    check("R7 ready after reset", req_ready, 1);
    check("R9 idle select", ebus_cs_n, 1);
    check("R9 idle strobes", {ebus_oe_n, ebus_we_n}, 2'b11);
    check("R9 idle drive", ebus_dout_en, 0);
    check("R3 no done after reset", rsp_done, 0);
    // R1: default timing 4/15/3 on the first access
    run_access(1'b0, 1'b0, 32'h2000_0003, 32'h0, 1'b0, 4'd0, 4'd0, 4'd0);
    check("R1 default lengths", m_s * 100 + m_a * 10 + m_h, 4 * 100 + 150 + 3);
    run_access(1'b0, 1'b1, 32'h2000_0006, 32'h0, 1'b0, 4'd0, 4'd0, 4'd0);
    run_access(1'b1, 1'b1, 32'h2000_0000, 32'hCAFE_1234, 1'b0, 4'd0, 4'd0, 4'd0);
    run_access(1'b1, 1'b0, 32'h2001_2346, 32'h0000_BEEF, 1'b0, 4'd0, 4'd0, 4'd0);
    // R8: zero programs one cycle per phase
    set_cfg(4'd0, 4'd0, 4'd0);
    run_access(1'b0, 1'b1, 32'h200F_FFFC, 32'h0, 1'b0, 4'd0, 4'd0, 4'd0);
    // R8: rewrite mid-access keeps old lengths, next access uses new
    set_cfg(4'd2, 4'd3, 4'd1);
    run_access(1'b1, 1'b1, 32'h2000_0100, 32'h1357_9BDF, 1'b1, 4'd6, 4'd9, 4'd2);
    check("R8 new timing loaded", m_s * 100 + m_a * 10 + m_h, 6 * 100 + 90 + 2);
    run_access(1'b0, 1'b0, 32'h2000_0102, 32'h0, 1'b0, 4'd0, 4'd0, 4'd0);
    // random accesses with random timing
    for (int i = 0; i < 120; i++) begin
      logic [31:0] a, d;
      if ($urandom % 4 == 0)
        set_cfg(4'($urandom % 16), 4'($urandom % 16), 4'($urandom % 16));
      a = 32'h2000_0000 + ($urandom % 32'h0020_0000);
      d = $urandom;
      run_access(1'($urandom % 2), 1'($urandom % 2), a, d,
                 ($urandom % 8) == 0, 4'($urandom % 16), 4'($urandom % 16), 4'($urandom % 16));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule